// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This block is the memory-access stage of a small 32-bit in-order core. It receives one decoded load or store at a time, carrying the access size, the signedness, an addressing mode, two register operands, an immediate field, the current program counter and the current stack pointer. From these it forms an effective address and checks that the access is legal and naturally aligned. It then drives a single 32-bit data-memory port with a valid/ready handshake and per-byte write strobes.

Load data is pulled from the correct little-endian lane and zero- or sign-extended before it goes back to the register file. It arrives there with a write enable and a 3-bit destination index. An access that is misaligned, or that uses an illegal combination of mode and size, is reported on a one-cycle fault output. It reaches neither memory nor the register file. Only one request is in flight at a time: the requester sees `req_ready` high only while the unit is idle.

Top module: `lsu_unit`

## Requirements
- R1: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A byte store replicates its low 8 bits into all four lanes and asserts only strobe bit `addr[1:0]`. A halfword store replicates its low 16 bits into both halves and asserts strobes 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1. A word store asserts 4'b1111 with the data unchanged.
- R2: Mode 0 (register offset) uses the address `req_base + req_offset`, for every size and for both loads and stores.
- R3: Mode 1 (short immediate) uses `req_base` plus bits [4:0] of `req_imm`, zero-extended and shifted left by 2 for word, 1 for halfword and 0 for byte. Bits [7:5] of `req_imm` have no effect in this mode.
- R4: Mode 2 (PC-relative) uses the address `((req_pc + 4) with bits [1:0] cleared) + req_imm*4`. It is legal only for a word load; a store or a narrow size in this mode raises the fault.
- R5: Mode 3 (stack-relative) uses the address `req_sp + req_imm*4`. It is legal for word loads and word stores only; a narrow size raises the fault.
- R6: A byte load selects byte `addr[1:0]` of `mem_rdata` (little-endian). A halfword load selects bits [31:16] when `addr[1]` is 1 and bits [15:0] otherwise. With `req_signed` = 1 the narrow value is sign-extended to 32 bits, and with 0 it is zero-extended. A word load returns `mem_rdata` unchanged whatever `req_signed` is.
- R7: A word address with `addr[1:0]` ≠ 0, a halfword address with `addr[0]` = 1, size 3, or an illegal mode combination from R4 or R5 makes `fault` high for exactly the one cycle after acceptance. Such a request produces no `mem_valid` and no `wb_en`.
- R8: A legal request accepted on a clock edge raises `mem_valid` on the next cycle. `mem_addr`, `mem_wdata`, `mem_strb` and `mem_write` then hold steady until the cycle in which `mem_ready` is high. `req_ready` stays low from acceptance until that completing edge.
- R9: A load completes on the edge where `mem_valid` and `mem_ready` are both high. In the next cycle `wb_en` is high for exactly one cycle, with `wb_rd` equal to the request's `req_rd` and `wb_data` as defined by R6. A store never raises `wb_en`.
- R10: `mem_write` is 1 for stores and 0 for loads, and `mem_strb` is 4'b0000 during a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_size | input | 2 | Access size (R1 encoding) |
| req_mode | input | 2 | Addressing mode (R2 to R5 encoding) |
| req_rd | input | 3 | Destination register index for a load |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Offset register value |
| req_imm | input | 8 | Immediate field |
| req_pc | input | 32 | Program counter of the instruction |
| req_sp | input | 32 | Current stack pointer |
| req_wdata | input | 32 | Store source register value |
| mem_valid | output | 1 | Memory transaction pending |
| mem_ready | input | 1 | Memory completes the transaction |
| mem_write | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, lanes replicated |
| mem_strb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 3 | Register write index |
| wb_data | output | 32 | Extended load result |
| fault | output | 1 | Misalignment or illegal combination |

## Verification
The assertions assume that memory returns `mem_rdata` in the same cycle it raises `mem_ready`, and that `mem_ready` has meaning only while `mem_valid` is high. The request fields are sampled only on the accepting edge, so they need not stay stable afterwards. The stimulus raises `mem_ready` only while a transaction is pending, after a wait of zero to two cycles. It presents `mem_rdata` from a 64-word behavioural memory together with `mem_ready`. It drops `req_valid` after every accepted request, so no request is ever left waiting at the port.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam int LSU_XLEN = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } lsu_size_e;

   typedef enum logic [1:0] {
      AM_REGREG = 2'd0,
      AM_IMMSH  = 2'd1,
      AM_PCREL  = 2'd2,
      AM_SPREL  = 2'd3
   } lsu_mode_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int AW          = 32,
   parameter int IMM_SHORT_W = 5,
   parameter int IMM_LONG_W  = 8,
   parameter int PC_ADVANCE  = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  lsu_mode_e             mode,
   input  lsu_size_e             size,
   input  logic [AW-1:0]         base,
   input  logic [AW-1:0]         offset,
   input  logic [AW-1:0]         pc,
   input  logic [AW-1:0]         sp,
   input  logic [IMM_LONG_W-1:0] imm,
   output logic [AW-1:0]         addr
);

   localparam int WORD_SHIFT = 2;

   if (IMM_SHORT_W > IMM_LONG_W) begin : g_bad_imm
      $error("lsu_agen: short immediate wider than long immediate");
   end

   logic [AW-1:0] short_ofs;
   logic [AW-1:0] long_ofs;
   logic [AW-1:0] pc_base;

   always_comb begin
      short_ofs = AW'(imm[IMM_SHORT_W-1:0]) << size;
      long_ofs  = AW'(imm) << WORD_SHIFT;
      pc_base   = (pc + AW'(PC_ADVANCE)) & ~AW'(3);
   end

   if (SHARED_ADDER) begin : g_shared
      logic [AW-1:0] op_a;
      logic [AW-1:0] op_b;
      always_comb begin
         unique case (mode)
            AM_REGREG: begin op_a = base;    op_b = offset;    end
            AM_IMMSH:  begin op_a = base;    op_b = short_ofs; end
            AM_PCREL:  begin op_a = pc_base; op_b = long_ofs;  end
            AM_SPREL:  begin op_a = sp;      op_b = long_ofs;  end
            default:   begin op_a = base;    op_b = offset;    end
         endcase
      end
      assign addr = op_a + op_b;
   end else begin : g_parallel
      logic [AW-1:0] sum_rr;
      logic [AW-1:0] sum_imm;
      logic [AW-1:0] sum_pc;
      logic [AW-1:0] sum_sp;
      assign sum_rr  = base + offset;
      assign sum_imm = base + short_ofs;
      assign sum_pc  = pc_base + long_ofs;
      assign sum_sp  = sp + long_ofs;
      always_comb begin
         unique case (mode)
            AM_REGREG: addr = sum_rr;
            AM_IMMSH:  addr = sum_imm;
            AM_PCREL:  addr = sum_pc;
            AM_SPREL:  addr = sum_sp;
            default:   addr = sum_rr;
         endcase
      end
   end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
   import lsu_pkg::*;
#(
   parameter int OFS_W = 2
) (
   input  lsu_mode_e        mode,
   input  lsu_size_e        size,
   input  logic             write,
   input  logic [OFS_W-1:0] addr_lo,
   output logic             bad
);

   if (OFS_W < 2) begin : g_bad_ofs
      $error("lsu_align_chk: lane offset must cover a word");
   end

   logic illegal_combo;
   logic misaligned;

   always_comb begin
      illegal_combo = (size == SZ_RSVD)
                    | ((mode == AM_PCREL) & (write | (size != SZ_WORD)))
                    | ((mode == AM_SPREL) & (size != SZ_WORD));
      unique case (size)
         SZ_WORD: misaligned = (addr_lo[1:0] != 2'b00);
         SZ_HALF: misaligned = addr_lo[0];
         default: misaligned = 1'b0;
      endcase
      bad = illegal_combo | misaligned;
   end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
   import lsu_pkg::*;
#(
   parameter int DW = 32
) (
   input  lsu_size_e                   size,
   input  logic [$clog2(DW/8)-1:0]     addr_lo,
   input  logic [DW-1:0]               din,
   output logic [DW-1:0]               dout,
   output logic [DW/8-1:0]             strb
);

   localparam int NB = DW / 8;
   localparam int OW = $clog2(NB);

   if (NB < 4) begin : g_bad_dw
      $error("lsu_store_lane: bus must hold a word");
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic       lane_en;
      logic [7:0] lane_byte;
      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               lane_en   = (addr_lo == OW'(i));
               lane_byte = din[7:0];
            end
            SZ_HALF: begin
               lane_en   = (addr_lo[OW-1:1] == (OW-1)'(i / 2));
               lane_byte = din[8*(i%2) +: 8];
            end
            default: begin
               lane_en   = 1'b1;
               lane_byte = din[8*i +: 8];
            end
         endcase
      end
      assign strb[i]          = lane_en;
      assign dout[8*i +: 8]   = lane_byte;
   end

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
   import lsu_pkg::*;
#(
   parameter int DW = 32
) (
   input  lsu_size_e               size,
   input  logic                    sext,
   input  logic [$clog2(DW/8)-1:0] addr_lo,
   input  logic [DW-1:0]           rdata,
   output logic [DW-1:0]           dout
);

   localparam int OW = $clog2(DW / 8);
   localparam int SW = OW + 3;

   logic [SW-1:0] byte_sh;
   logic [SW-1:0] half_sh;
   logic [DW-1:0] byte_al;
   logic [DW-1:0] half_al;

   always_comb begin
      byte_sh = {addr_lo, 3'b000};
      half_sh = {addr_lo[OW-1:1], 1'b0, 3'b000};
      byte_al = rdata >> byte_sh;
      half_al = rdata >> half_sh;
      unique case (size)
         SZ_BYTE: dout = {{(DW-8){sext & byte_al[7]}}, byte_al[7:0]};
         SZ_HALF: dout = {{(DW-16){sext & half_al[15]}}, half_al[15:0]};
         default: dout = rdata;
      endcase
   end

endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
   import lsu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int REG_IDX_W    = 3,
   parameter int IMM_SHORT_W  = 5,
   parameter int IMM_LONG_W   = 8,
   parameter int PC_ADVANCE   = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_store,
   input  logic                  req_signed,
   input  logic [1:0]            req_size,
   input  logic [1:0]            req_mode,
   input  logic [REG_IDX_W-1:0]  req_rd,
   input  logic [DATA_W-1:0]     req_base,
   input  logic [DATA_W-1:0]     req_offset,
   input  logic [IMM_LONG_W-1:0] req_imm,
   input  logic [DATA_W-1:0]     req_pc,
   input  logic [DATA_W-1:0]     req_sp,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  mem_valid,
   input  logic                  mem_ready,
   output logic                  mem_write,
   output logic [DATA_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W/8-1:0]   mem_strb,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  wb_en,
   output logic [REG_IDX_W-1:0]  wb_rd,
   output logic [DATA_W-1:0]     wb_data,
   output logic                  fault
);

   localparam int NB = DATA_W / 8;
   localparam int OW = $clog2(NB);

   if (DATA_W != LSU_XLEN) begin : g_bad_width
      $error("lsu_unit: data width must match the core word");
   end
   if (REG_IDX_W < 1) begin : g_bad_idx
      $error("lsu_unit: register index must be at least one bit");
   end

   typedef enum logic {ST_IDLE, ST_WAIT} lsu_state_e;

   lsu_size_e size_in;
   lsu_mode_e mode_in;
   assign size_in = lsu_size_e'(req_size);
   assign mode_in = lsu_mode_e'(req_mode);

   logic [DATA_W-1:0] eff_addr;
   logic              req_bad;
   logic [DATA_W-1:0] st_bus;
   logic [NB-1:0]     st_strb;
   logic [DATA_W-1:0] ld_value;

   lsu_state_e           st_q;
   logic [DATA_W-1:0]    addr_q;
   logic                 write_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [NB-1:0]        strb_q;
   lsu_size_e            size_q;
   logic                 sext_q;
   logic [REG_IDX_W-1:0] rd_q;
   logic                 wb_en_q;
   logic [REG_IDX_W-1:0] wb_rd_q;
   logic [DATA_W-1:0]    wb_data_q;
   logic                 fault_q;

   lsu_agen #(
      .AW           (DATA_W),
      .IMM_SHORT_W  (IMM_SHORT_W),
      .IMM_LONG_W   (IMM_LONG_W),
      .PC_ADVANCE   (PC_ADVANCE),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_agen (
      .mode   (mode_in),
      .size   (size_in),
      .base   (req_base),
      .offset (req_offset),
      .pc     (req_pc),
      .sp     (req_sp),
      .imm    (req_imm),
      .addr   (eff_addr)
   );

   lsu_align_chk #(
      .OFS_W (OW)
   ) u_align (
      .mode    (mode_in),
      .size    (size_in),
      .write   (req_store),
      .addr_lo (eff_addr[OW-1:0]),
      .bad     (req_bad)
   );

   lsu_store_lane #(
      .DW (DATA_W)
   ) u_stlane (
      .size    (size_in),
      .addr_lo (eff_addr[OW-1:0]),
      .din     (req_wdata),
      .dout    (st_bus),
      .strb    (st_strb)
   );

   lsu_load_ext #(
      .DW (DATA_W)
   ) u_ldext (
      .size    (size_q),
      .sext    (sext_q),
      .addr_lo (addr_q[OW-1:0]),
      .rdata   (mem_rdata),
      .dout    (ld_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         write_q   <= 1'b0;
         wdata_q   <= '0;
         strb_q    <= '0;
         size_q    <= SZ_WORD;
         sext_q    <= 1'b0;
         rd_q      <= '0;
         wb_en_q   <= 1'b0;
         wb_rd_q   <= '0;
         wb_data_q <= '0;
         fault_q   <= 1'b0;
      end else begin
         wb_en_q <= 1'b0;
         fault_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_bad) begin
                     fault_q <= 1'b1;
                  end else begin
                     st_q    <= ST_WAIT;
                     addr_q  <= eff_addr;
                     write_q <= req_store;
                     wdata_q <= req_store ? st_bus : '0;
                     strb_q  <= req_store ? st_strb : '0;
                     size_q  <= size_in;
                     sext_q  <= req_signed;
                     rd_q    <= req_rd;
                  end
               end
            end
            ST_WAIT: begin
               if (mem_ready) begin
                  st_q <= ST_IDLE;
                  if (!write_q) begin
                     wb_en_q   <= 1'b1;
                     wb_rd_q   <= rd_q;
                     wb_data_q <= ld_value;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign mem_valid = (st_q == ST_WAIT);
   assign mem_write = write_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign mem_strb  = strb_q;
   assign wb_en     = wb_en_q;
   assign wb_rd     = wb_rd_q;
   assign wb_data   = wb_data_q;
   assign fault     = fault_q;

   a_r8_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)
                                     && $stable(mem_strb) && $stable(mem_write)))
      else $error("R8: memory request changed before ready");

   a_r8_ready_excludes_pending: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_valid)
      else $error("R8: request accepted while a transaction pends");

   a_r9_wb_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(mem_valid && mem_ready && !mem_write))
      else $error("R9: write-back without a completed read");

   a_r9_wb_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> !wb_en)
      else $error("R9: write-back lasted more than one cycle");

   a_r9_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && mem_write) |=> !wb_en)
      else $error("R9: store produced a write-back");

   a_r7_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!mem_valid && !wb_en))
      else $error("R7: fault together with a transaction");

   a_r7_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !mem_valid)
      else $error("R7: faulting request reached memory");

   a_r10_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_write) |-> (mem_strb == '0))
      else $error("R10: strobes on a read");

   a_r1_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> (($countones(mem_strb) == 1) || ($countones(mem_strb) == 2)
                                    || ($countones(mem_strb) == 4)))
      else $error("R1: store strobe pattern malformed");

endmodule

// File: tb/lsu_unit_bench.sv
`timescale 1ns/1ps
module lsu_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic        req_signed = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [1:0]  req_mode = 2'd0;
   logic [2:0]  req_rd = 3'd0;
   logic [31:0] req_base = '0;
   logic [31:0] req_offset = '0;
   logic [7:0]  req_imm = '0;
   logic [31:0] req_pc = '0;
   logic [31:0] req_sp = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic        mem_write;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_strb;
   logic [31:0] mem_rdata = '0;
   logic        wb_en;
   logic [2:0]  wb_rd;
   logic [31:0] wb_data;
   logic        fault;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   logic [31:0] model_mem [64];

   always #5 clk = ~clk;

   lsu_unit u_lsu_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_signed,
      .req_size, .req_mode, .req_rd, .req_base, .req_offset, .req_imm,
      .req_pc, .req_sp, .req_wdata, .mem_valid, .mem_ready, .mem_write,
      .mem_addr, .mem_wdata, .mem_strb, .mem_rdata, .wb_en, .wb_rd,
      .wb_data, .fault
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_addr(input logic [1:0] sz, input logic [1:0] md,
                                            input logic [31:0] base, input logic [31:0] off,
                                            input logic [7:0] imm, input logic [31:0] pc,
                                            input logic [31:0] sp);
      int unsigned scale;
      scale = (sz == 2'd2) ? 4 : (sz == 2'd1) ? 2 : (sz == 2'd0) ? 1 : 8;
      case (md)
         2'd0:    return base + off;
         2'd1:    return base + 32'(int'(imm % 32) * scale);
         2'd2:    return ((pc + 32'd4) / 4) * 4 + 32'(imm) * 4;
         default: return sp + 32'(imm) * 4;
      endcase
   endfunction

   function automatic bit ref_fault(input bit st, input logic [1:0] sz, input logic [1:0] md,
                                    input logic [31:0] a);
      if (sz == 2'd3) return 1'b1;
      if (md == 2'd2 && (st || sz != 2'd2)) return 1'b1;
      if (md == 2'd3 && sz != 2'd2) return 1'b1;
      if (sz == 2'd2 && (a % 4) != 0) return 1'b1;
      if (sz == 2'd1 && (a % 2) != 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic do_req(input string tag, input bit st, input bit sg, input logic [1:0] sz,
                         input logic [1:0] md, input logic [31:0] base, input logic [31:0] off,
                         input logic [7:0] imm, input logic [31:0] pc, input logic [31:0] sp,
                         input logic [31:0] wd, input logic [2:0] rd, input int wait_cycles);
      logic [31:0] ea;
      logic [31:0] exp_wd;
      logic [3:0]  exp_strb;
      logic [31:0] word;
      logic [31:0] exp_ld;
      int          lane;
      bit          flt;
      ea  = ref_addr(sz, md, base, off, imm, pc, sp);
      flt = ref_fault(st, sz, md, ea);
      lane = int'(ea % 4);
      if (sz == 2'd0) begin
         exp_strb = 4'(1 << lane);
         exp_wd   = {4{wd[7:0]}};
      end else if (sz == 2'd1) begin
         exp_strb = (lane >= 2) ? 4'b1100 : 4'b0011;
         exp_wd   = {2{wd[15:0]}};
      end else begin
         exp_strb = 4'b1111;
         exp_wd   = wd;
      end
      word = model_mem[ea[7:2]];
      if (sz == 2'd0) begin
         exp_ld = (word >> (8 * lane)) & 32'hFF;
         if (sg && exp_ld >= 32'h80) exp_ld = exp_ld | 32'hFFFF_FF00;
      end else if (sz == 2'd1) begin
         exp_ld = (word >> ((lane >= 2) ? 16 : 0)) & 32'hFFFF;
         if (sg && exp_ld >= 32'h8000) exp_ld = exp_ld | 32'hFFFF_0000;
      end else begin
         exp_ld = word;
      end

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_store = st; req_signed = sg; req_size = sz; req_mode = md;
      req_base = base; req_offset = off; req_imm = imm; req_pc = pc; req_sp = sp;
      req_wdata = wd; req_rd = rd;
      @(negedge clk);
      req_valid = 1'b0;
      if (flt) begin
         check({tag, " R7 fault"}, 32'(fault), 32'd1);
         check({tag, " R7 no mem"}, 32'(mem_valid), 32'd0);
         @(negedge clk);
         check({tag, " R7 fault one cycle"}, 32'(fault), 32'd0);
         check({tag, " R7 no wb"}, 32'(wb_en), 32'd0);
         check({tag, " R7 no mem later"}, 32'(mem_valid), 32'd0);
         return;
      end
      check({tag, " R8 mem_valid"}, 32'(mem_valid), 32'd1);
      check({tag, " R7 no fault"}, 32'(fault), 32'd0);
      check({tag, " R2-R5 addr"}, mem_addr, ea);
      check({tag, " R10 write"}, 32'(mem_write), 32'(st));
      if (st) begin
         check({tag, " R1 strb"}, 32'(mem_strb), 32'(exp_strb));
         check({tag, " R1 wdata"}, mem_wdata, exp_wd);
      end else begin
         check({tag, " R10 read strb"}, 32'(mem_strb), 32'd0);
      end
      for (int k = 0; k < wait_cycles; k++) begin
         @(negedge clk);
         check({tag, " R8 held valid"}, 32'(mem_valid), 32'd1);
         check({tag, " R8 held addr"}, mem_addr, ea);
         check({tag, " R8 ready low"}, 32'(req_ready), 32'd0);
         check({tag, " R9 no early wb"}, 32'(wb_en), 32'd0);
      end
      mem_ready = 1'b1;
      mem_rdata = word;
      if (st) begin
         for (int b = 0; b < 4; b++)
            if (exp_strb[b]) model_mem[ea[7:2]][8*b +: 8] = exp_wd[8*b +: 8];
      end
      @(negedge clk);
      mem_ready = 1'b0;
      mem_rdata = 32'hDEAD_BEEF;
      check({tag, " R8 done"}, 32'(mem_valid), 32'd0);
      if (st) begin
         check({tag, " R9 store no wb"}, 32'(wb_en), 32'd0);
      end else begin
         check({tag, " R9 wb_en"}, 32'(wb_en), 32'd1);
         check({tag, " R9 wb_rd"}, 32'(wb_rd), 32'(rd));
         check({tag, " R6 wb_data"}, wb_data, exp_ld);
         @(negedge clk);
         check({tag, " R9 wb one cycle"}, 32'(wb_en), 32'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model_mem[i] = 32'h8070_6050 ^ (32'(i) * 32'h0101_0101);
      repeat (3) @(negedge clk);
      check("reset req_ready", 32'(req_ready), 32'd1);
      check("reset mem_valid R8", 32'(mem_valid), 32'd0);
      check("reset wb_en R9", 32'(wb_en), 32'd0);
      check("reset fault R7", 32'(fault), 32'd0);
      rst_n = 1'b1;

      do_req("R2 word store",     1, 0, 2'd2, 2'd0, 32'h10, 32'h4, 8'h0, 0, 0, 32'h1234_5678, 3'd0, 1);
      do_req("R2 word load",      0, 0, 2'd2, 2'd0, 32'h10, 32'h4, 8'h0, 0, 0, 0, 3'd5, 0);
      do_req("R1 byte store",     1, 0, 2'd0, 2'd1, 32'h20, 0, 8'h03, 0, 0, 32'h55AB, 3'd0, 2);
      do_req("R1 half store",     1, 0, 2'd1, 2'd1, 32'h20, 0, 8'h00, 0, 0, 32'h7788_8001, 3'd0, 0);
      do_req("R6 signed byte",    0, 1, 2'd0, 2'd0, 32'h20, 32'h3, 8'h0, 0, 0, 0, 3'd1, 1);
      do_req("R6 unsigned byte",  0, 0, 2'd0, 2'd0, 32'h20, 32'h3, 8'h0, 0, 0, 0, 3'd2, 0);
      do_req("R6 signed half",    0, 1, 2'd1, 2'd0, 32'h20, 32'h0, 8'h0, 0, 0, 0, 3'd3, 0);
      do_req("R6 unsigned half",  0, 0, 2'd1, 2'd0, 32'h20, 32'h0, 8'h0, 0, 0, 0, 3'd4, 0);
      do_req("R6 upper half",     0, 1, 2'd1, 2'd1, 32'h30, 0, 8'h01, 0, 0, 0, 3'd6, 0);
      do_req("R1 half store hi",  1, 0, 2'd1, 2'd0, 32'h30, 32'h2, 8'h0, 0, 0, 32'hCAFE, 3'd0, 0);
      do_req("R3 word imm max",   0, 0, 2'd2, 2'd1, 32'h0, 0, 8'h1F, 0, 0, 0, 3'd7, 0);
      do_req("R3 upper imm bits", 0, 0, 2'd0, 2'd1, 32'h40, 0, 8'hE1, 0, 0, 0, 3'd0, 0);
      do_req("R4 pc relative",    0, 0, 2'd2, 2'd2, 0, 0, 8'h03, 32'h102, 0, 0, 3'd2, 0);
      do_req("R4 pc store fault", 1, 0, 2'd2, 2'd2, 0, 0, 8'h03, 32'h100, 0, 32'h1, 3'd0, 0);
      do_req("R4 pc byte fault",  0, 0, 2'd0, 2'd2, 0, 0, 8'h03, 32'h100, 0, 0, 3'd0, 0);
      do_req("R5 sp store",       1, 0, 2'd2, 2'd3, 0, 0, 8'h02, 0, 32'h40, 32'hA5A5_0F0F, 3'd0, 0);
      do_req("R5 sp load",        0, 0, 2'd2, 2'd3, 0, 0, 8'h02, 0, 32'h40, 0, 3'd3, 2);
      do_req("R5 sp half fault",  0, 0, 2'd1, 2'd3, 0, 0, 8'h02, 0, 32'h40, 0, 3'd0, 0);
      do_req("R7 word misalign",  0, 0, 2'd2, 2'd0, 32'h13, 0, 8'h0, 0, 0, 0, 3'd1, 0);
      do_req("R7 half odd",       1, 0, 2'd1, 2'd0, 32'h21, 0, 8'h0, 0, 0, 32'h1, 3'd0, 0);
      do_req("R7 reserved size",  0, 0, 2'd3, 2'd0, 32'h20, 0, 8'h0, 0, 0, 0, 3'd0, 0);
      do_req("R6 signed word",    0, 1, 2'd2, 2'd0, 32'h14, 0, 8'h0, 0, 0, 0, 3'd4, 0);

      for (int n = 0; n < 80; n++) begin
         do_req("R2 random", 1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4),
                2'($urandom % 4), 32'($urandom % 128), 32'($urandom % 64),
                8'($urandom % 256), 32'($urandom % 128), 32'($urandom % 64),
                $urandom, 3'($urandom % 8), int'($urandom % 3));
      end

      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule